// File: doc/BRIEF.md
# K-Best Survivor List Stage

This block is one layer of a breadth-first K-best tree-search detector. It takes in a batch of K surviving parent nodes from the previous layer, each carrying an accumulated partial Euclidean distance (PED), a symbol path, and one branch metric for each of its children. It keeps the batch in a register bank and then walks the parents one per cycle through a single shared child-metric path. The child metrics of the current parent are merged straight into a sorted list that always holds the K smallest PEDs seen so far in the batch.

After K cycles every child of every stored parent has been considered. The list is then presented as the survivor set for the next layer, for one cycle, together with the extended symbol paths. A 4x4 complex system chains 2x4 = 8 of these stages, one per real-valued tree layer. The metric unit is modelled as a saturating adder of parent PED and branch metric.

Top module: `kb_list_stage`

## Requirements
- R1: While reset is held and in the cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A batch is taken only on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 from that edge through the cycle in which `out_valid` is 1, and it is 1 again in the cycle after that.
- R3: `out_valid` rises exactly K clock edges after the accepting edge and stays high for exactly one cycle per batch.
- R4: The PED of child c of parent p is the parent PED plus branch metric `in_bm` field p*NCHILD+c, saturating at 2^PED_W-1.
- R5: When `out_valid` is 1, slot s of `out_ped`/`out_path` (bits s*W upward) holds the s-th smallest child PED of the batch, so slot 0 is the smallest and the slots never decrease.
- R6: A child's path is its parent's path shifted left by SYM_W = log2(NCHILD) bits, with the oldest bits dropped and the child index c in the low SYM_W bits.
- R7: Equal PEDs keep insertion order. A lower parent index comes first, and within one parent a lower child index comes first.
- R8: The list is cleared at each accepted batch to PED 2^PED_W-1 with path 0. A child whose PED saturates to that value never displaces an entry, so slots left unfilled show PED 2^PED_W-1 and path 0.
- R9: `in_valid` and input data presented while `in_ready` is 0 have no effect on the batch in progress or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A new parent batch is presented |
| in_ready | output | 1 | Stage is idle and will take a batch |
| in_ped | input | K*PED_W | Parent PEDs, parent p at bits p*PED_W |
| in_path | input | K*PATH_W | Parent symbol paths, parent p at bits p*PATH_W |
| in_bm | input | K*NCHILD*BM_W | Branch metrics, field p*NCHILD+c |
| out_valid | output | 1 | Survivor list is valid this cycle |
| out_ped | output | K*PED_W | Survivor PEDs, slot 0 smallest |
| out_path | output | K*PATH_W | Survivor symbol paths |

## Verification
The hardest cases to reach from the ports are equal PEDs and saturated children. The stimulus uses parent PEDs and branch metrics whose sums collide across parents and within one parent, which exercises the insertion-order rule. It also uses parents near or at the PED ceiling, so that some sums clamp and some list slots must stay cleared. A second batch is also offered while the stage is busy. The following result must still match the first batch.

// File: rtl/kb_pkg.sv
package kb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } kb_state_e;
endpackage

// File: rtl/kb_metric.sv
// Child metric unit: all children of one parent in one cycle.
module kb_metric #(
  parameter int NCHILD = 8,
  parameter int PED_W  = 12,
  parameter int BM_W   = 8,
  parameter int PATH_W = 24,
  parameter int SYM_W  = 3
) (
  input  logic [PED_W-1:0]         par_ped,
  input  logic [PATH_W-1:0]        par_path,
  input  logic [NCHILD*BM_W-1:0]   bm_row,
  output logic [NCHILD*PED_W-1:0]  ch_ped,
  output logic [NCHILD*PATH_W-1:0] ch_path
);
  localparam logic [PED_W-1:0] PED_MAX = '1;

  for (genvar c = 0; c < NCHILD; c++) begin : g_child
    logic [PED_W:0] sum;
    always_comb begin
      sum = {1'b0, par_ped} + (PED_W+1)'(bm_row[c*BM_W +: BM_W]);
      ch_ped[c*PED_W +: PED_W] = sum[PED_W] ? PED_MAX : sum[PED_W-1:0];
      ch_path[c*PATH_W +: PATH_W] = {par_path[PATH_W-SYM_W-1:0], SYM_W'(c)};
    end
  end
endmodule

// File: rtl/kb_insert.sv
// One insertion into an ascending list; the last entry falls off.
module kb_insert #(
  parameter int K      = 8,
  parameter int PED_W  = 12,
  parameter int PATH_W = 24
) (
  input  logic [K*PED_W-1:0]  li_ped,
  input  logic [K*PATH_W-1:0] li_path,
  input  logic [PED_W-1:0]    nw_ped,
  input  logic [PATH_W-1:0]   nw_path,
  output logic [K*PED_W-1:0]  lo_ped,
  output logic [K*PATH_W-1:0] lo_path
);
  logic [K-1:0] below;

  for (genvar i = 0; i < K; i++) begin : g_slot
    assign below[i] = nw_ped < li_ped[i*PED_W +: PED_W];
    if (i == 0) begin : g_head
      always_comb begin
        lo_ped[0 +: PED_W]   = below[0] ? nw_ped  : li_ped[0 +: PED_W];
        lo_path[0 +: PATH_W] = below[0] ? nw_path : li_path[0 +: PATH_W];
      end
    end else begin : g_body
      always_comb begin
        if (!below[i]) begin
          lo_ped[i*PED_W +: PED_W]    = li_ped[i*PED_W +: PED_W];
          lo_path[i*PATH_W +: PATH_W] = li_path[i*PATH_W +: PATH_W];
        end else if (!below[i-1]) begin
          lo_ped[i*PED_W +: PED_W]    = nw_ped;
          lo_path[i*PATH_W +: PATH_W] = nw_path;
        end else begin
          lo_ped[i*PED_W +: PED_W]    = li_ped[(i-1)*PED_W +: PED_W];
          lo_path[i*PATH_W +: PATH_W] = li_path[(i-1)*PATH_W +: PATH_W];
        end
      end
    end
  end
endmodule

// File: rtl/kb_ctrl.sv
// Batch sequencer: accept, K parent steps, one-cycle hand-off.
module kb_ctrl #(
  parameter int K     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             load,
  output logic             step,
  output logic [IDX_W-1:0] par_idx,
  output logic             out_valid
);
  import kb_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(K-1);

  kb_state_e state;

  assign in_ready  = (state == ST_IDLE);
  assign load      = in_ready && in_valid;
  assign step      = (state == ST_RUN);
  assign out_valid = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      par_idx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          state   <= ST_RUN;
          par_idx <= '0;
        end
        ST_RUN: begin
          par_idx <= par_idx + 1'b1;
          if (par_idx == LAST) state <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kb_list_stage.sv
// One K-best layer: register bank, shared metric path, insertion list.
module kb_list_stage #(
  parameter int K        = 8,
  parameter int NCHILD   = 8,
  parameter int PED_W    = 12,
  parameter int BM_W     = 8,
  parameter int PATH_LEN = 8,
  localparam int SYM_W   = (NCHILD > 1) ? $clog2(NCHILD) : 1,
  localparam int PATH_W  = PATH_LEN * SYM_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [K*PED_W-1:0]       in_ped,
  input  logic [K*PATH_W-1:0]      in_path,
  input  logic [K*NCHILD*BM_W-1:0] in_bm,
  output logic                     out_valid,
  output logic [K*PED_W-1:0]       out_ped,
  output logic [K*PATH_W-1:0]      out_path
);
  localparam int IDX_W = (K > 1) ? $clog2(K) : 1;
  localparam int ROW_W = NCHILD * BM_W;

  logic             load, step;
  logic [IDX_W-1:0] par_idx;

  kb_ctrl #(.K(K), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .load(load), .step(step), .par_idx(par_idx), .out_valid(out_valid)
  );

  // Parent register bank, read one entry per cycle.
  logic [PED_W-1:0]  bank_ped  [K];
  logic [PATH_W-1:0] bank_path [K];
  logic [ROW_W-1:0]  bank_bm   [K];

  always_ff @(posedge clk) begin
    if (load) begin
      for (int p = 0; p < K; p++) begin
        bank_ped[p]  <= in_ped[p*PED_W +: PED_W];
        bank_path[p] <= in_path[p*PATH_W +: PATH_W];
        bank_bm[p]   <= in_bm[p*ROW_W +: ROW_W];
      end
    end
  end

  logic [PED_W-1:0]         cur_ped;
  logic [PATH_W-1:0]        cur_path;
  logic [ROW_W-1:0]         cur_bm;
  logic [NCHILD*PED_W-1:0]  ch_ped;
  logic [NCHILD*PATH_W-1:0] ch_path;

  assign cur_ped  = bank_ped[par_idx];
  assign cur_path = bank_path[par_idx];
  assign cur_bm   = bank_bm[par_idx];

  kb_metric #(
    .NCHILD(NCHILD), .PED_W(PED_W), .BM_W(BM_W), .PATH_W(PATH_W), .SYM_W(SYM_W)
  ) u_metric (
    .par_ped(cur_ped), .par_path(cur_path), .bm_row(cur_bm),
    .ch_ped(ch_ped), .ch_path(ch_path)
  );

  // Survivor list and the insertion chain, child 0 first.
  logic [K*PED_W-1:0]  lst_ped;
  logic [K*PATH_W-1:0] lst_path;
  logic [K*PED_W-1:0]  chain_ped  [NCHILD+1];
  logic [K*PATH_W-1:0] chain_path [NCHILD+1];

  assign chain_ped[0]  = lst_ped;
  assign chain_path[0] = lst_path;

  for (genvar c = 0; c < NCHILD; c++) begin : g_ins
    kb_insert #(.K(K), .PED_W(PED_W), .PATH_W(PATH_W)) u_ins (
      .li_ped(chain_ped[c]), .li_path(chain_path[c]),
      .nw_ped(ch_ped[c*PED_W +: PED_W]), .nw_path(ch_path[c*PATH_W +: PATH_W]),
      .lo_ped(chain_ped[c+1]), .lo_path(chain_path[c+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      lst_ped  <= '1;
      lst_path <= '0;
    end else if (step) begin
      lst_ped  <= chain_ped[NCHILD];
      lst_path <= chain_path[NCHILD];
    end
  end

  assign out_ped  = lst_ped;
  assign out_path = lst_path;
endmodule

// File: rtl/kb_list_stage_chk.sv
module kb_list_stage_chk #(
  parameter int K     = 8,
  parameter int PED_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic [K*PED_W-1:0] out_ped
);
  localparam int CW = $clog2(K + 2);

  logic          busy;
  logic [CW-1:0] since;
  logic          ordered;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      since <= '0;
    end else if (in_valid && in_ready) begin
      busy  <= 1'b1;
      since <= '0;
    end else if (busy) begin
      since <= since + 1'b1;
      if (out_valid) busy <= 1'b0;
    end
  end

  always_comb begin
    ordered = 1'b1;
    for (int i = 1; i < K; i++)
      if (out_ped[i*PED_W +: PED_W] < out_ped[(i-1)*PED_W +: PED_W]) ordered = 1'b0;
  end

  p_reset_state_r1: assert property (@(posedge clk) rst |=> (!out_valid && in_ready));
  p_busy_blocks_r2: assert property (@(posedge clk) disable iff (rst) busy |-> !in_ready);
  p_ready_back_r2:  assert property (@(posedge clk) disable iff (rst) out_valid |=> in_ready);
  p_latency_r3:     assert property (@(posedge clk) disable iff (rst)
                                     out_valid |-> (busy && since == CW'(K)));
  p_one_pulse_r3:   assert property (@(posedge clk) disable iff (rst) out_valid |=> !out_valid);
  p_ascending_r5:   assert property (@(posedge clk) disable iff (rst) out_valid |-> ordered);
endmodule

bind kb_list_stage kb_list_stage_chk #(.K(K), .PED_W(PED_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ped(out_ped)
);

// File: tb/tb_kb_list_stage.sv
`timescale 1ns/1ps
module tb_kb_list_stage;
  localparam int K = 8, NCH = 8, PED_W = 12, BM_W = 8, PLEN = 8;
  localparam int SYM_W = 3, PATH_W = PLEN * SYM_W;
  localparam logic [PED_W-1:0] MAXP = '1;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic in_ready, out_valid;
  logic [K*PED_W-1:0] in_ped = '0, out_ped;
  logic [K*PATH_W-1:0] in_path = '0, out_path;
  logic [K*NCH*BM_W-1:0] in_bm = '0;

  always #2 clk = ~clk;

  kb_list_stage #(.K(K), .NCHILD(NCH), .PED_W(PED_W), .BM_W(BM_W), .PATH_LEN(PLEN)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_ped(in_ped), .in_path(in_path), .in_bm(in_bm),
    .out_valid(out_valid), .out_ped(out_ped), .out_path(out_path)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [PED_W-1:0]  s_ped  [K];
  logic [PATH_W-1:0] s_path [K];
  logic [BM_W-1:0]   s_bm   [K][NCH];

  logic [K*PED_W-1:0]  q_ped  [$];
  logic [K*PATH_W-1:0] q_path [$];
  int                  q_acc  [$];
  string               q_tag  [$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Reference: repeated stable minimum search over all children (R4 R6 R7 R8).
  task automatic expect_list(output logic [K*PED_W-1:0] ep, output logic [K*PATH_W-1:0] eh);
    logic [PED_W-1:0]  cp [K*NCH];
    logic [PATH_W-1:0] ch [K*NCH];
    bit used [K*NCH];
    for (int p = 0; p < K; p++)
      for (int c = 0; c < NCH; c++) begin
        int sum = int'(s_ped[p]) + int'(s_bm[p][c]);
        cp[p*NCH+c] = (sum > int'(MAXP)) ? MAXP : PED_W'(sum);
        ch[p*NCH+c] = (s_path[p] << SYM_W) | PATH_W'(c);
        used[p*NCH+c] = 0;
      end
    for (int s = 0; s < K; s++) begin
      int best = -1;
      for (int j = 0; j < K*NCH; j++)
        if (!used[j] && cp[j] != MAXP && (best < 0 || cp[j] < cp[best])) best = j;
      if (best < 0) begin
        ep[s*PED_W +: PED_W] = MAXP;
        eh[s*PATH_W +: PATH_W] = '0;
      end else begin
        used[best] = 1;
        ep[s*PED_W +: PED_W] = cp[best];
        eh[s*PATH_W +: PATH_W] = ch[best];
      end
    end
  endtask

  task automatic pack_inputs();
    for (int p = 0; p < K; p++) begin
      in_ped[p*PED_W +: PED_W] = s_ped[p];
      in_path[p*PATH_W +: PATH_W] = s_path[p];
      for (int c = 0; c < NCH; c++) in_bm[(p*NCH+c)*BM_W +: BM_W] = s_bm[p][c];
    end
  endtask

  // Driver: present the batch, wait for acceptance, push the expectation.
  task automatic send_batch(input string tag);
    logic [K*PED_W-1:0] ep;
    logic [K*PATH_W-1:0] eh;
    expect_list(ep, eh);
    @(negedge clk);
    pack_inputs();
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    q_ped.push_back(ep); q_path.push_back(eh);
    q_acc.push_back(cyc); q_tag.push_back(tag);
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (q_ped.size() == 0) begin
        check(0, "R3", "unexpected out_valid", 1, 0);
      end else begin
        logic [K*PED_W-1:0] ep;
        logic [K*PATH_W-1:0] eh;
        int acc;
        string tag;
        ep = q_ped.pop_front(); eh = q_path.pop_front();
        acc = q_acc.pop_front(); tag = q_tag.pop_front();
        check(cyc - acc == K, "R3", "latency", cyc - acc, K);
        check(in_ready == 1'b0, "R2", "in_ready during out_valid", in_ready, 0);
        for (int s = 0; s < K; s++) begin
          check(out_ped[s*PED_W +: PED_W] == ep[s*PED_W +: PED_W], tag, "slot ped",
                out_ped[s*PED_W +: PED_W], ep[s*PED_W +: PED_W]);
          check(out_path[s*PATH_W +: PATH_W] == eh[s*PATH_W +: PATH_W], tag, "slot path",
                out_path[s*PATH_W +: PATH_W], eh[s*PATH_W +: PATH_W]);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "R3", "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    rst = 1'b0;

    // R5 R6: varied random batches
    for (int t = 0; t < 6; t++) begin
      for (int p = 0; p < K; p++) begin
        s_ped[p] = PED_W'($urandom_range(0, 1500));
        s_path[p] = PATH_W'($urandom);
        for (int c = 0; c < NCH; c++) s_bm[p][c] = BM_W'($urandom);
      end
      send_batch("R5_R6_random");
    end

    // R7: every child identical, order must follow insertion
    for (int p = 0; p < K; p++) begin
      s_ped[p] = 12'd100; s_path[p] = PATH_W'(p * 7 + 1);
      for (int c = 0; c < NCH; c++) s_bm[p][c] = 8'd5;
    end
    send_batch("R7_all_equal");

    // R7: collisions spread over parents and children
    for (int p = 0; p < K; p++) begin
      s_ped[p] = 12'd200 + 12'(p % 2); s_path[p] = PATH_W'(32'hFFF000 + p);
      for (int c = 0; c < NCH; c++) s_bm[p][c] = BM_W'((p + c) % 3);
    end
    send_batch("R7_mixed_ties");

    // R4 R8: near the PED ceiling; only six children fit, two slots stay cleared
    for (int p = 0; p < K; p++) begin
      s_ped[p] = (p < 2) ? 12'd4090 : MAXP; s_path[p] = PATH_W'(32'h00ABC0 + p);
      for (int c = 0; c < NCH; c++) s_bm[p][c] = BM_W'(c * 2);
    end
    send_batch("R4_R8_saturate");

    // R5: later parents better, winners all from the last parent
    for (int p = 0; p < K; p++) begin
      s_ped[p] = 12'(1000 - p * 100); s_path[p] = PATH_W'(p);
      for (int c = 0; c < NCH; c++) s_bm[p][c] = BM_W'(NCH - c);
    end
    send_batch("R5_descending");

    // R9: a foreign batch offered while busy must be ignored
    for (int p = 0; p < K; p++) begin
      s_ped[p] = 12'(300 + p); s_path[p] = PATH_W'(p * 3);
      for (int c = 0; c < NCH; c++) s_bm[p][c] = BM_W'(c * 3 + p);
    end
    send_batch("R9_busy_ignored");
    for (int p = 0; p < K; p++) begin
      s_ped[p] = '0; s_path[p] = '1;
      for (int c = 0; c < NCH; c++) s_bm[p][c] = '0;
    end
    pack_inputs();
    in_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R2", "in_ready while busy", in_ready, 0);
    end
    in_valid = 1'b0;

    for (int i = 0; i < 200 && q_ped.size() != 0; i++) @(negedge clk);
    check(q_ped.size() == 0, "R3", "pending results", q_ped.size(), 0);
    repeat (2) @(negedge clk);
    check(in_ready == 1'b1, "R2", "in_ready after hand-off", in_ready, 1);
    summary();
  end
endmodule